// File: doc/BRIEF.md
# Sequential Dial Combination Lock

This block is a clocked finite state machine that behaves like a rotary safe lock. Each dial action is presented in a single cycle as one event: a strobe, a turn-direction bit and the number the dial stopped on. The lock opens only when three events arrive in the correct order: right to 13, then left to 22, then right to 3. A direction and a number form a pair. The same number turned the wrong way counts as a wrong entry.

The machine has four states: idle, one step done, two steps done, and open. A wrong entry sends it back to idle. A right-13 entry always starts a new attempt, so a user can begin again at once after a mistake. While the lock is open, dial events have no effect. Only a relock request or a reset closes it. The unlock output depends on the current state alone. The state code is brought out on a debug port.

Top module: `dial_combo_lock`

## Requirements
- R1: When the synchronous reset is high at a clock edge, the state after that edge is idle (code 00) and unlock is low, whatever the other inputs are.
- R2: The debug port shows the state as idle=00, one-step=01, two-step=10, open=11. Unlock is high exactly when the state is open (code 11), so it rises one cycle after the edge that accepts the final step.
- R3: The direction bit means right when it is 1 and left when it is 0. The valid events right-13, left-22 and right-3 move the state idle→01→10→11, one step for each accepted event.
- R4: On an edge where the event strobe is low and relock is low, the state does not change.
- R5: In states 00, 01 and 10, a valid event that is not the expected pair and is not right-13 returns the state to idle. This covers a correct number with the wrong direction.
- R6: In state 01 or 10, a valid right-13 event moves the state to 01, so a new attempt starts at once.
- R7: A dial value above 39 (the legal range is 0 to 39) never matches any step and counts as a wrong entry.
- R8: In state 11, valid dial events, including the right-13 restart pair, are ignored and the state stays 11.
- R9: Relock high in state 11 returns the state to idle on the next edge. In states 00, 01 and 10, relock has no effect and events are handled as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | A dial event is present this cycle |
| evt_dir | input | 1 | Turn direction: 1 = right, 0 = left |
| evt_val | input | 6 | Number the dial stopped on, unsigned |
| relock | input | 1 | Closes an open lock |
| unlocked | output | 1 | High while the lock is open |
| state_dbg | output | 2 | Current state code |

## Verification
The full correct sequence is driven from idle and also after idle gaps between steps. This shows that only strobed events advance the state and that waiting costs no progress. Each correct number is also sent with the wrong direction, and the correct numbers are sent in the wrong order. These patterns separate a lock that compares only values, or only the set of values, from one that compares ordered direction-value pairs. Out-of-range numbers whose low bits match a step check the range test. Right-13 sent in each partial state checks the restart path. Events and relock in the open state, and relock in the closed states, show that only the open state responds to relock and that it ignores the dial.

// File: rtl/dial_lock_pkg.sv
package dial_lock_pkg;

  // Number of ordered steps in the combination; four states follow from it.
  localparam int STEPS = 3;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'b00,
    LK_STEP1 = 2'b01,
    LK_STEP2 = 2'b10,
    LK_OPEN  = 2'b11
  } lock_state_e;

  localparam logic DIR_RIGHT = 1'b1;
  localparam logic DIR_LEFT  = 1'b0;

  // A dial reading is legal when it lies inside the printed scale.
  function automatic logic dial_legal(input logic [15:0] val, input logic [15:0] val_max);
    return (val <= val_max);
  endfunction

  // One step matches when the reading is legal and both direction and number agree.
  function automatic logic step_match(input logic        dir_in,
                                      input logic [15:0] val_in,
                                      input logic        dir_exp,
                                      input logic [15:0] val_exp,
                                      input logic [15:0] val_max);
    return dial_legal(val_in, val_max) && (dir_in == dir_exp) && (val_in == val_exp);
  endfunction

endpackage

// File: rtl/lock_step_match.sv
module lock_step_match
  import dial_lock_pkg::*;
#(
  parameter int                        VAL_W     = 6,
  parameter int                        DIAL_MAX  = 39,
  parameter logic [STEPS*VAL_W-1:0]    STEP_VALS = '0,
  parameter logic [STEPS-1:0]          STEP_DIRS = '0
) (
  input  logic              evt_dir,
  input  logic [VAL_W-1:0]  evt_val,
  output logic [STEPS-1:0]  hit_vec,
  output logic              dial_ok
);

  localparam logic [15:0] VMAX = 16'(DIAL_MAX);

  logic [15:0] val16;
  assign val16   = 16'(evt_val);
  assign dial_ok = dial_legal(val16, VMAX);

  // One comparator per combination step.
  for (genvar g = 0; g < STEPS; g++) begin : g_step
    logic [VAL_W-1:0] exp_val;
    assign exp_val    = STEP_VALS[g*VAL_W +: VAL_W];
    assign hit_vec[g] = step_match(evt_dir, val16, STEP_DIRS[g], 16'(exp_val), VMAX);
  end

endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import dial_lock_pkg::*;
(
  input  lock_state_e       state_q,
  input  logic              evt_valid,
  input  logic              relock,
  input  logic [STEPS-1:0]  hit_vec,
  output lock_state_e       state_d,
  output logic              step_ok,
  output logic              miss,
  output logic              restart
);

  // Expected-step hit for the current partial state.
  always_comb begin
    unique case (state_q)
      LK_IDLE:  step_ok = hit_vec[0];
      LK_STEP1: step_ok = hit_vec[1];
      LK_STEP2: step_ok = hit_vec[2];
      default:  step_ok = 1'b0;
    endcase
  end

  assign restart = evt_valid && hit_vec[0] && !step_ok && (state_q != LK_OPEN);
  assign miss    = evt_valid && !step_ok && (state_q != LK_OPEN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LK_IDLE, LK_STEP1, LK_STEP2: begin
        if (evt_valid) begin
          if (step_ok) begin
            unique case (state_q)
              LK_IDLE:  state_d = LK_STEP1;
              LK_STEP1: state_d = LK_STEP2;
              default:  state_d = LK_OPEN;
            endcase
          end else if (restart) begin
            state_d = LK_STEP1;
          end else begin
            state_d = LK_IDLE;
          end
        end
      end
      LK_OPEN: begin
        if (relock) state_d = LK_IDLE;
      end
      default: state_d = LK_IDLE;
    endcase
  end

endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg
  import dial_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lock_state_e state_d,
  output lock_state_e state_q,
  output logic        unlocked
);

  always_ff @(posedge clk) begin
    if (rst) state_q <= LK_IDLE;
    else     state_q <= state_d;
  end

  // Moore output: a function of the stored state only.
  assign unlocked = (state_q == LK_OPEN);

  AST_OPEN_FROM_STEP2: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(state_q) == LK_STEP2)); // R3

endmodule

// File: rtl/dial_combo_lock.sv
module dial_combo_lock
  import dial_lock_pkg::*;
#(
  parameter int   VAL_W    = 6,
  parameter int   DIAL_MAX = 39,
  parameter int   S1_VAL   = 13,
  parameter logic S1_DIR   = DIR_RIGHT,
  parameter int   S2_VAL   = 22,
  parameter logic S2_DIR   = DIR_LEFT,
  parameter int   S3_VAL   = 3,
  parameter logic S3_DIR   = DIR_RIGHT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic             evt_dir,
  input  logic [VAL_W-1:0] evt_val,
  input  logic             relock,
  output logic             unlocked,
  output logic [1:0]       state_dbg
);

  localparam logic [STEPS*VAL_W-1:0] STEP_VALS =
    {VAL_W'(S3_VAL), VAL_W'(S2_VAL), VAL_W'(S1_VAL)};
  localparam logic [STEPS-1:0] STEP_DIRS = {S3_DIR, S2_DIR, S1_DIR};

  logic [STEPS-1:0] hit_vec;
  logic             dial_ok;
  logic             step_ok;
  logic             miss;
  logic             restart;
  lock_state_e      state_d;
  lock_state_e      state_q;

  lock_step_match #(
    .VAL_W     (VAL_W),
    .DIAL_MAX  (DIAL_MAX),
    .STEP_VALS (STEP_VALS),
    .STEP_DIRS (STEP_DIRS)
  ) i_match (
    .evt_dir (evt_dir),
    .evt_val (evt_val),
    .hit_vec (hit_vec),
    .dial_ok (dial_ok)
  );

  lock_next_state i_next (
    .state_q   (state_q),
    .evt_valid (evt_valid),
    .relock    (relock),
    .hit_vec   (hit_vec),
    .state_d   (state_d),
    .step_ok   (step_ok),
    .miss      (miss),
    .restart   (restart)
  );

  lock_state_reg i_reg (
    .clk      (clk),
    .rst      (rst),
    .state_d  (state_d),
    .state_q  (state_q),
    .unlocked (unlocked)
  );

  assign state_dbg = state_q;

  AST_HOLD_IDLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!evt_valid && !relock) |=> $stable(state_q)); // R4
  AST_MISS_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (miss && !restart) |=> (state_q == LK_IDLE)); // R5
  AST_RESTART_STEP1: assert property (@(posedge clk) disable iff (rst)
    restart |=> (state_q == LK_STEP1)); // R6
  AST_ILLEGAL_NEVER_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !dial_ok && state_q != LK_OPEN) |=> (state_q == LK_IDLE)); // R7
  AST_OPEN_IGNORES_DIAL: assert property (@(posedge clk) disable iff (rst)
    (state_q == LK_OPEN && !relock) |=> (state_q == LK_OPEN)); // R8
  AST_RELOCK_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (state_q == LK_OPEN && relock) |=> (state_q == LK_IDLE && !unlocked)); // R9

endmodule

// File: tb/test_dial_combo_lock.sv
`timescale 1ns/1ps
module test_dial_combo_lock;

  typedef struct {
    int    exp_st;
    string tag;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt_valid = 1'b0;
  logic       evt_dir = 1'b0;
  logic [5:0] evt_val = '0;
  logic       relock = 1'b0;
  logic       unlocked;
  logic [1:0] state_dbg;

  int n_tests = 0;
  int n_fail  = 0;
  int model_st = 0;
  exp_item_t sb_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  dial_combo_lock i_dial_combo_lock (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .evt_dir   (evt_dir),
    .evt_val   (evt_val),
    .relock    (relock),
    .unlocked  (unlocked),
    .state_dbg (state_dbg)
  );

  // Reference model written from the requirements.
  function automatic int ref_next(int s, bit r, bit v, bit d, int val, bit rl);
    int want_val;
    bit want_dir;
    if (r) return 0;
    if (s == 3) return rl ? 0 : 3;
    if (!v) return s;
    case (s)
      0: begin want_val = 13; want_dir = 1'b1; end
      1: begin want_val = 22; want_dir = 1'b0; end
      default: begin want_val = 3; want_dir = 1'b1; end
    endcase
    if (val > 39) return 0;
    if (d == want_dir && val == want_val) return s + 1;
    if (d == 1'b1 && val == 13) return 1;
    return 0;
  endfunction

  // Driver: apply one cycle of inputs and queue the expected result.
  task automatic step(bit r, bit v, bit d, int val, bit rl, string tag);
    @(negedge clk);
    rst = r; evt_valid = v; evt_dir = d; evt_val = 6'(val); relock = rl;
    model_st = ref_next(model_st, r, v, d, val, rl);
    @(posedge clk);
    sb_q.push_back('{exp_st: model_st, tag: tag});
  endtask

  task automatic ev(bit d, int val, string tag);
    step(1'b0, 1'b1, d, val, 1'b0, tag);
  endtask

  task automatic idle(string tag);
    step(1'b0, 1'b0, 1'b0, 0, 1'b0, tag);
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      n_tests++;
      if (state_dbg !== 2'(it.exp_st) || unlocked !== (it.exp_st == 3)) begin
        n_fail++;
        $display("FAIL %s: state=%b unlocked=%b expected state=%b unlocked=%b",
                 it.tag, state_dbg, unlocked, 2'(it.exp_st), (it.exp_st == 3));
      end
    end
  end

  initial begin
    step(1'b1, 1'b0, 1'b0, 0, 1'b0, "R1 reset idle");
    step(1'b1, 1'b1, 1'b1, 13, 1'b1, "R1 reset dominates event");
    // R3/R2 correct sequence
    ev(1'b1, 13, "R3 first step");
    ev(1'b0, 22, "R3 second step");
    ev(1'b1, 3,  "R3 R2 opens");
    // R8 ignore dial while open
    ev(1'b1, 13, "R8 restart pair ignored");
    ev(1'b0, 7,  "R8 wrong pair ignored");
    idle("R8 R4 open holds");
    // R9 relock
    step(1'b0, 1'b1, 1'b1, 13, 1'b1, "R9 relock closes");
    // R4 gaps between steps
    ev(1'b1, 13, "R3 step1 again");
    idle("R4 hold step1");
    idle("R4 hold step1 b");
    ev(1'b0, 22, "R3 step2 after gap");
    idle("R4 hold step2");
    // R9 relock ignored in partial state
    step(1'b0, 1'b0, 1'b0, 0, 1'b1, "R9 relock no effect in 10");
    ev(1'b1, 3, "R3 opens after gaps");
    step(1'b0, 1'b0, 1'b0, 0, 1'b1, "R9 relock only");
    // R5 wrong direction
    ev(1'b0, 13, "R5 left13 in idle");
    ev(1'b1, 13, "R6 start");
    ev(1'b1, 22, "R5 right22 in 01");
    ev(1'b1, 13, "R6 start b");
    ev(1'b0, 22, "R3 to 10");
    ev(1'b0, 3,  "R5 left3 in 10");
    // R5 wrong order
    ev(1'b0, 22, "R5 left22 in idle");
    ev(1'b1, 3,  "R5 right3 in idle");
    // R6 restarts
    ev(1'b1, 13, "R6 to 01");
    ev(1'b1, 13, "R6 right13 in 01");
    ev(1'b0, 22, "R6 to 10");
    ev(1'b1, 13, "R6 right13 in 10");
    ev(1'b0, 22, "R6 continue to 10");
    ev(1'b1, 3,  "R6 opens after restart");
    step(1'b0, 1'b0, 1'b0, 0, 1'b1, "R9 relock");
    // R7 out of range: 45 = 13+32, 54 = 22+32, 35 = 3+32 (35 legal but wrong)
    ev(1'b1, 45, "R7 45 in idle");
    ev(1'b1, 13, "R7 to 01");
    ev(1'b0, 54, "R7 54 in 01");
    ev(1'b1, 13, "R7 to 01 b");
    ev(1'b0, 22, "R7 to 10");
    ev(1'b1, 63, "R7 63 in 10");
    ev(1'b1, 40, "R7 40 in idle");
    // R1 reset from open
    ev(1'b1, 13, "R3 s1");
    ev(1'b0, 22, "R3 s2");
    ev(1'b1, 3,  "R3 s3");
    step(1'b1, 1'b0, 1'b0, 0, 1'b0, "R1 reset from open");
    idle("R1 R4 after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule